// File: doc/BRIEF.md
# Channelized running checksum register

This block is an application endpoint behind a byte-wide channel pipe interface with 128 logical channels. A 7-bit channel address picks the channel. The host writes bytes through a host-to-device pipe (data, valid, ready) and reads bytes through a device-to-host pipe (data, valid, ready). Neither pipe ever stalls: the write pipe is always ready and the read pipe always holds valid data.

Every byte written to the data channel (channel 0) is shown on eight LED outputs and is added into a 16-bit running sum, which wraps modulo 65536. Two sum channels hold the upper and lower bytes of the accumulator. The host can read either of them, and it can overwrite either one without disturbing the other. Reads of the data channel return the eight switch inputs. The full 16-bit sum is also driven raw to a hex display port.

The reset input is active-low and clears the block at once. Its release passes through a two-stage synchronizer, so the block starts accepting writes on the third rising edge after the reset input rises.

Top module: `chan_sum_reg`

## Requirements
- R1: While the reset input is low, the sum output and the LED output are zero, and they clear as soon as reset is asserted, without waiting for a clock edge.
- R2: A write strobe on channel 0 adds the zero-extended byte to the 16-bit sum at that clock edge, and the result wraps modulo 65536 (0xFFFF plus 0x02 gives 0x0001).
- R3: The LED output takes the byte of each write accepted on channel 0. Writes to any other channel leave it unchanged.
- R4: A write to channel 1 replaces bits 15:8 of the sum, and a write to channel 2 replaces bits 7:0. The other byte keeps its value in both cases.
- R5: Read data follows the channel address combinationally in the same cycle: channel 0 gives the switch inputs, channel 1 gives sum bits 15:8, and channel 2 gives sum bits 7:0.
- R6: The write-ready output and the read-valid output are high in every cycle.
- R7: A write with valid low, or a write to any channel from 3 to 127, changes neither the sum nor the LEDs. Reads of channels 3 to 127 return 0x00.
- R8: Asserting read-ready never changes the sum or the LEDs.
- R9: After 0x00 has been written to channels 1 and 2, writing the bytes CA FE BA BE F0 0D 1E to channel 0 leaves channel 1 reading 0x04 and channel 2 reading 0x5B (sum 0x045B).
- R10: After the reset input rises, writes at the first two rising edges are ignored. The third rising edge is the first one that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserts asynchronously and releases synchronously |
| chan_addr_i | input | 7 | Channel address for both pipes |
| wr_data_i | input | 8 | Host-to-device byte |
| wr_valid_i | input | 1 | Host-to-device byte valid |
| wr_ready_o | output | 1 | Host-to-device ready, always high |
| rd_data_o | output | 8 | Device-to-host byte for the addressed channel |
| rd_valid_o | output | 1 | Device-to-host valid, always high |
| rd_ready_i | input | 1 | Device-to-host ready; a read has no side effect |
| switch_i | input | 8 | Switch inputs returned on channel 0 |
| led_o | output | 8 | Last byte accepted on channel 0 |
| sum_o | output | 16 | Running sum for the hex display |

## Verification
The bench targets the corner cases where a wrong design shows a visible symptom:
- **Carry past bit 15.** A design that kept the carry, or that added into only the low byte, would give a wrong result after 0xFFFF plus 0x02.
- **Byte-lane writes.** A design that swapped the lanes or cleared the other byte would fail the overwrite checks on channels 1 and 2.
- **Unused channels and reads.** Writes to unused channels and reads with read-ready held high are interleaved with real writes. A decoder that aliased on the low address bits would corrupt the sum, and a read with a side effect would change it.
- **Reset edges.** Reset is asserted in the middle of a cycle and released with writes pending. A missing asynchronous clear, or a synchronizer with the wrong depth, would show up as a sum that is non-zero or accepted one edge early or late.

// File: rtl/chan_sum_pkg.sv
package chan_sum_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/chan_sum_rst_sync.sv
module chan_sum_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = pipe_q[STAGES-1];
endmodule

// File: rtl/chan_sum_decode.sv
module chan_sum_decode #(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned NLANES    = 2,
  parameter int unsigned ADD_CH    = 0,
  parameter int unsigned LANE_BASE = 1
) (
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              add_o,
  output logic [NLANES-1:0] lane_o
);
  assign add_o = strobe_i && (addr_i == ADDR_W'(ADD_CH));

  // lane 0 is the most significant byte of the accumulator
  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    assign lane_o[k] = strobe_i && (addr_i == ADDR_W'(LANE_BASE + k));
  end
endmodule

// File: rtl/chan_sum_accum.sv
module chan_sum_accum
  import chan_sum_pkg::*;
#(
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned NLANES = SUM_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [NLANES-1:0] lane_i,
  input  byte_t             data_i,
  output logic [SUM_W-1:0]  sum_o,
  output byte_t             led_o
);
  logic [SUM_W-1:0] sum_q, sum_d;
  byte_t            led_q, led_d;
  logic             sum_en, led_en;

  always_comb begin
    sum_d  = sum_q;
    led_d  = led_q;
    sum_en = add_i || (|lane_i);
    led_en = add_i;
    if (add_i) begin
      sum_d = sum_q + SUM_W'(data_i);
      led_d = data_i;
    end
    for (int k = 0; k < NLANES; k++) begin
      if (lane_i[k]) sum_d[SUM_W-1-k*BYTE_W -: BYTE_W] = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      led_q <= '0;
    end else begin
      if (sum_en) sum_q <= sum_d;
      if (led_en) led_q <= led_d;
    end
  end

  assign sum_o = sum_q;
  assign led_o = led_q;
endmodule

// File: rtl/chan_sum_rdmux.sv
module chan_sum_rdmux
  import chan_sum_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned SUM_W     = 16,
  parameter int unsigned NLANES    = SUM_W / BYTE_W,
  parameter int unsigned ADD_CH    = 0,
  parameter int unsigned LANE_BASE = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             switch_i,
  input  logic [SUM_W-1:0]  sum_i,
  output byte_t             rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(ADD_CH)) rd_data_o = switch_i;
    for (int k = 0; k < NLANES; k++) begin
      if (addr_i == ADDR_W'(LANE_BASE + k)) rd_data_o = sum_i[SUM_W-1-k*BYTE_W -: BYTE_W];
    end
  end
endmodule

// File: rtl/chan_sum_reg.sv
module chan_sum_reg
  import chan_sum_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SUM_W       = 16,
  parameter int unsigned ADD_CH      = 0,
  parameter int unsigned LANE_BASE   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] chan_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  input  logic [7:0]        switch_i,
  output logic [7:0]        led_o,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int unsigned NLANES = SUM_W / BYTE_W;

  logic              rst_core_n;
  logic              wr_strobe;
  logic              add_en;
  logic [NLANES-1:0] lane_en;
  logic              rd_ready_unused;

  // neither pipe ever applies back-pressure
  assign wr_ready_o      = 1'b1;
  assign rd_valid_o      = 1'b1;
  assign wr_strobe       = wr_valid_i && wr_ready_o;
  assign rd_ready_unused = rd_ready_i;

  chan_sum_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  chan_sum_decode #(
    .ADDR_W(ADDR_W), .NLANES(NLANES), .ADD_CH(ADD_CH), .LANE_BASE(LANE_BASE)
  ) u_dec (
    .strobe_i (wr_strobe),
    .addr_i   (chan_addr_i),
    .add_o    (add_en),
    .lane_o   (lane_en)
  );

  chan_sum_accum #(.SUM_W(SUM_W), .NLANES(NLANES)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .add_i  (add_en),
    .lane_i (lane_en),
    .data_i (wr_data_i),
    .sum_o  (sum_o),
    .led_o  (led_o)
  );

  chan_sum_rdmux #(
    .ADDR_W(ADDR_W), .SUM_W(SUM_W), .NLANES(NLANES),
    .ADD_CH(ADD_CH), .LANE_BASE(LANE_BASE)
  ) u_rd (
    .addr_i    (chan_addr_i),
    .switch_i  (switch_i),
    .sum_i     (sum_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/chan_sum_reg_chk.sv
module chan_sum_reg_chk #(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SUM_W       = 16,
  parameter int unsigned ADD_CH      = 0,
  parameter int unsigned LANE_BASE   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] chan_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              wr_valid_i,
  input logic [7:0]        rd_data_o,
  input logic [7:0]        switch_i,
  input logic [7:0]        led_o,
  input logic [SUM_W-1:0]  sum_o
);
  localparam int unsigned NLANES = SUM_W / 8;
  localparam int unsigned HI_CH  = LANE_BASE;
  localparam int unsigned LO_CH  = LANE_BASE + NLANES - 1;
  localparam int unsigned LAST_CH = LO_CH;

  logic [3:0] since_q;
  logic       live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_q <= '0;
    else if (since_q != 4'(SYNC_STAGES)) since_q <= since_q + 4'd1;
  end
  assign live = (since_q == 4'(SYNC_STAGES));

  // R1
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (sum_o == '0 && led_o == '0));

  // R2
  a_r2_add_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_valid_i && chan_addr_i == ADDR_W'(ADD_CH))
    |=> sum_o == ($past(sum_o) + SUM_W'($past(wr_data_i))));

  // R3
  a_r3_led_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_valid_i && chan_addr_i == ADDR_W'(ADD_CH))
    |=> led_o == $past(wr_data_i));

  // R4
  a_r4_hi_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_valid_i && chan_addr_i == ADDR_W'(HI_CH))
    |=> (sum_o[SUM_W-1 -: 8] == $past(wr_data_i)
         && sum_o[SUM_W-9:0] == $past(sum_o[SUM_W-9:0])));

  // R4
  a_r4_lo_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_valid_i && chan_addr_i == ADDR_W'(LO_CH))
    |=> (sum_o[7:0] == $past(wr_data_i)
         && sum_o[SUM_W-1:8] == $past(sum_o[SUM_W-1:8])));

  // R5
  a_r5_read_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_addr_i == ADDR_W'(ADD_CH) |-> rd_data_o == switch_i);

  // R5
  a_r5_read_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_addr_i == ADDR_W'(HI_CH) |-> rd_data_o == sum_o[SUM_W-1 -: 8])
    and (chan_addr_i == ADDR_W'(LO_CH) |-> rd_data_o == sum_o[7:0]));

  // R7
  a_r7_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_i && chan_addr_i <= ADDR_W'(LAST_CH))
    |=> ($stable(sum_o) && $stable(led_o)));

  // R7
  a_r7_unused_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_addr_i > ADDR_W'(LAST_CH) |-> rd_data_o == 8'h00);

  // R10
  a_r10_release_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> (sum_o == '0 && led_o == '0));
endmodule

bind chan_sum_reg chan_sum_reg_chk #(
  .ADDR_W(ADDR_W), .SUM_W(SUM_W), .ADD_CH(ADD_CH),
  .LANE_BASE(LANE_BASE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_chan_sum_reg.sv
module sim_chan_sum_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  addr;
  logic [7:0]  wdata, rdata, sw, led;
  logic        wvalid, wready, rvalid, rready;
  logic [15:0] sum;

  always #10 clk = ~clk;  // 50 MHz

  chan_sum_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_addr_i(addr),
    .wr_data_i(wdata), .wr_valid_i(wvalid), .wr_ready_o(wready),
    .rd_data_o(rdata), .rd_valid_o(rvalid), .rd_ready_i(rready),
    .switch_i(sw), .led_o(led), .sum_o(sum)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference
  logic [15:0] m_sum = '0;
  logic [7:0]  m_led = '0;
  bit          m_q0 = 1'b0, m_q1 = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [6:0] a);
    case (a)
      7'd0:    return sw;
      7'd1:    return m_sum[15:8];
      7'd2:    return m_sum[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare();
    chk(rst_n ? "R2 sum" : "R1 sum in reset", sum, m_sum);
    chk(rst_n ? "R3 led" : "R1 led in reset", {8'h00, led}, {8'h00, m_led});
    chk(addr < 7'd3 ? "R5 read data" : "R7 unused read", {8'h00, rdata}, {8'h00, m_read(addr)});
    chk("R6 wr_ready", {15'h0, wready}, 16'd1);
    chk("R6 rd_valid", {15'h0, rvalid}, 16'd1);
  endtask

  task automatic model_edge();
    bit acc;
    if (!rst_n) begin
      m_q0 = 1'b0; m_q1 = 1'b0; m_sum = '0; m_led = '0;
    end else begin
      acc  = m_q1;
      m_q1 = m_q0;
      m_q0 = 1'b1;
      if (acc && wvalid) begin
        case (addr)
          7'd0: begin m_sum = m_sum + {8'h00, wdata}; m_led = wdata; end
          7'd1: m_sum[15:8] = wdata;
          7'd2: m_sum[7:0]  = wdata;
          default: ;
        endcase
      end
    end
  endtask

  // compare on every clock, then drive, then follow the edge
  task automatic step(input logic [6:0] a, input logic v, input logic [7:0] d, input logic r);
    @(negedge clk);
    compare();
    addr = a; wvalid = v; wdata = d; rready = r;
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    step(a, 1'b1, d, 1'b0);
  endtask

  task automatic rd(input logic [6:0] a);
    step(a, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [7:0]  bytes [7];
    bytes = '{8'hCA, 8'hFE, 8'hBA, 8'hBE, 8'hF0, 8'h0D, 8'h1E};
    rst_n = 1'b1; addr = '0; wdata = '0; wvalid = 1'b0; rready = 1'b0; sw = 8'h3C;
    #3 rst_n = 1'b0;
    m_sum = '0; m_led = '0; m_q0 = 1'b0; m_q1 = 1'b0;

    // R1: held in reset, writes pending
    for (int i = 0; i < 3; i++) wr(7'd0, 8'h77);
    #2 chk("R1 sum held in reset", sum, 16'h0000);

    // R10: release, two ignored edges, third accepted
    rst_n = 1'b1;
    wr(7'd0, 8'h55);
    wr(7'd0, 8'h55);
    #2 chk("R10 writes ignored after release", sum, 16'h0000);
    wr(7'd0, 8'h55);
    #2 chk("R10 first accepted write", sum, 16'h0055);
    chk("R3 led after first write", {8'h00, led}, 16'h0055);

    // R9: known checksum vector
    wr(7'd1, 8'h00);
    wr(7'd2, 8'h00);
    foreach (bytes[i]) wr(7'd0, bytes[i]);
    #2 chk("R9 sum after vector", sum, 16'h045B);
    rd(7'd1);
    #2 chk("R9 channel 1 read", {8'h00, rdata}, 16'h0004);
    rd(7'd2);
    #2 chk("R9 channel 2 read", {8'h00, rdata}, 16'h005B);
    chk("R3 led holds last byte", {8'h00, led}, 16'h001E);

    // R4: lane overwrites
    wr(7'd1, 8'hCA);
    #2 chk("R4 high lane write", sum, 16'hCA5B);
    wr(7'd2, 8'hFE);
    #2 chk("R4 low lane write", sum, 16'hCAFE);
    chk("R3 led unchanged by lane writes", {8'h00, led}, 16'h001E);

    // R5: switch read follows input combinationally
    rd(7'd0);
    sw = 8'hA5;
    #1 chk("R5 switch read", {8'h00, rdata}, 16'h00A5);

    // R7: ignored writes and unused reads
    wr(7'd3, 8'h11);
    wr(7'd127, 8'h22);
    wr(7'd64, 8'h33);
    step(7'd0, 1'b0, 8'h44, 1'b0);
    #2 chk("R7 sum unchanged", sum, 16'hCAFE);
    chk("R7 led unchanged", {8'h00, led}, 16'h001E);
    rd(7'd66);
    #2 chk("R7 unused channel reads zero", {8'h00, rdata}, 16'h0000);

    // R8: reads have no side effect
    for (int i = 0; i < 6; i++) rd(7'(i % 3));
    #2 chk("R8 sum unchanged by reads", sum, 16'hCAFE);

    // R2: wrap past 0xFFFF
    wr(7'd1, 8'hFF);
    wr(7'd2, 8'hFF);
    wr(7'd0, 8'h02);
    #2 chk("R2 wrap modulo 65536", sum, 16'h0001);

    // mixed traffic compared every clock
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sw = lfsr[13:6];
      step({5'b0, lfsr[1:0]} + (lfsr[2] ? 7'd0 : {lfsr[9:7], 4'd0}),
           lfsr[4], lfsr[15:8], lfsr[5]);
    end

    // R1: asynchronous clear mid-cycle
    wr(7'd0, 8'h9C);
    #5 rst_n = 1'b0;
    m_sum = '0; m_led = '0; m_q0 = 1'b0; m_q1 = 1'b0;
    #2 chk("R1 asynchronous sum clear", sum, 16'h0000);
    chk("R1 asynchronous led clear", {8'h00, led}, 16'h0000);
    wr(7'd0, 8'h12);
    #2 rst_n = 1'b1;
    wr(7'd0, 8'h01);
    wr(7'd0, 8'h02);
    wr(7'd0, 8'h03);
    #2 chk("R10 second release", sum, 16'h0003);
    step(7'd0, 1'b0, 8'h00, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule